// File: doc/BRIEF.md
# Shared Twiddle Constant Multiplier

This block rotates one complex sample per clock by a power of the sixteenth root of unity, W16^m = cos(pi*m/8) - j*sin(pi*m/8). It serves the twiddle stages of a radix-4^2 single-path delay feedback transform. It covers every factor those stages need: the W16 exponent sets {0,1,2,3}, {0,2,4,6} and {0,3,6,9} used by the forward and inverse transforms, and W8^k (equal to W16^(2k)) used by the cosine-transform mode. In place of a general multiplier it holds only three fixed-point constants, built from shifts and adds. These are cos(pi/8), sin(pi/8) and cos(pi/4). Every factor is reached by combining those products, then swapping the real and imaginary parts and inverting signs.

The caller presents a 13-bit signed sample, a 4-bit exponent and a valid strobe. One clock later the rotated sample appears on a 14-bit output together with a delayed valid. The output is one bit wider than the input, so full-scale inputs never wrap. Exponents that are multiples of four bypass the constant arithmetic and are exact.

Top module: `twiddle_const_mult`

## Requirements
- R1: The 4-bit input `tw_idx` holds the exponent m, and the block multiplies by W16^m. A W8^k factor is requested as m = 2k. Write m = 4*qd + fr, where qd = m[3:2] is the quadrant and fr = m[1:0] is the fraction.
- R2: Reset (active-low `rst_n`) clears `out_valid`, `out_re` and `out_im` to zero. After reset, `out_valid` equals `in_valid` from the previous cycle. A sample can be accepted on every cycle.
- R3: While `in_valid` is low, `out_re` and `out_im` keep their previous values, whatever the data and exponent inputs carry.
- R4: When fr = 0, the result is exact. For m=0 it is (a, b). For m=4 it is (b, -a). For m=8 it is (-a, -b). For m=12 it is (-b, a). Here a is the real input and b is the imaginary input.
- R5: The constants are integer numerators over 2^13. C1 = 2^13 - 2^9 - 2^6 - 2^5 - 2^4 = 7568. S1 = 2^11 + 2^10 + 2^6 + 2^1 - 2^0 = 3137. C2 = 2^12 + 2^10 + 2^9 + 2^7 + 2^5 + 2^1 = 5794.
- R6: When fr = 1, the pre-rotation pair is P = floor((a*C1 + b*S1)/2^13) and Q = floor((b*C1 - a*S1)/2^13). Each product sum is formed at full precision and then truncated toward minus infinity.
- R7: When fr = 2, P = floor((a+b)*C2/2^13) and Q = floor((b-a)*C2/2^13).
- R8: When fr = 3, P = floor((a*S1 + b*C1)/2^13) and Q = floor((b*S1 - a*C1)/2^13).
- R9: The quadrant is applied after truncation. qd=0 gives (P, Q), qd=1 gives (Q, -P), qd=2 gives (-P, -Q) and qd=3 gives (-Q, P). The 14-bit outputs hold every result for any 13-bit input pair, including (-4096, -4096).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_tw_idx | input | 4 | W16 exponent m |
| in_re | input | 13 | Real part of the sample, signed |
| in_im | input | 13 | Imaginary part of the sample, signed |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_re | output | 14 | Real part of the rotated sample, signed |
| out_im | output | 14 | Imaginary part of the rotated sample, signed |

## Verification
The clocked properties assume that reset is held for at least one edge, and that data and exponent inputs are changed away from the rising edge. The bench meets both by driving on the falling edge only. The no-overflow property on the truncated products assumes 13-bit two's-complement inputs of any value. The stimulus therefore includes the most negative pair, mixed extreme signs and a free-running pseudo-random sweep over the full input range. It also drives junk on the data and exponent pins during idle cycles, so that the hold property is exercised with changing inputs rather than quiet ones.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int TWC_FRAC  = 13;   // fraction bits of the constants
  localparam int TWC_ACC_W = 32;   // full-precision accumulator width
  localparam int TWC_ROOTS = 16;   // W16 exponent space
  localparam int TWC_IDX_W = $clog2(TWC_ROOTS);

  typedef logic signed [TWC_ACC_W-1:0] twc_acc_t;

  // x scaled by 2^-k, held at a scale of 2^TWC_FRAC (exact, no bits lost)
  function automatic twc_acc_t twc_sh(input twc_acc_t x, input int k);
    return x <<< (TWC_FRAC - k);
  endfunction

  // drop the fraction: floor toward minus infinity
  function automatic twc_acc_t twc_floor(input twc_acc_t v);
    return v >>> TWC_FRAC;
  endfunction
endpackage

// File: rtl/twc_index_decode.sv
module twc_index_decode
  import twc_pkg::*;
(
  input  logic [TWC_IDX_W-1:0] idx,
  output logic [1:0]           frac_sel,
  output logic [1:0]           quad,
  output logic                 bypass
);
  // R1: m = 4*quad + frac_sel
  assign frac_sel = idx[1:0];
  assign quad     = idx[TWC_IDX_W-1 -: 2];
  assign bypass   = (idx[1:0] == 2'd0);
endmodule

// File: rtl/twc_shift_lane.sv
module twc_shift_lane
  import twc_pkg::*;
(
  input  twc_acc_t x,
  output twc_acc_t kc1,
  output twc_acc_t ks1,
  output twc_acc_t kc2
);
  // R5: shared partial sums between the three constants
  twc_acc_t t3_12, t4_8, t7;

  assign t3_12 = twc_sh(x, 3) + twc_sh(x, 12);
  assign t4_8  = twc_sh(x, 4) + twc_sh(x, 8);
  assign t7    = twc_sh(x, 7);

  assign kc1 = twc_sh(x, 0) - t4_8 - t7 - twc_sh(x, 9);
  assign ks1 = twc_sh(x, 2) + t3_12 + t7 - twc_sh(x, 13);
  assign kc2 = twc_sh(x, 1) + t3_12 + t4_8 + twc_sh(x, 6);
endmodule

// File: rtl/twc_const_core.sv
module twc_const_core
  import twc_pkg::*;
#(
  parameter int DW = 13
)(
  input  logic [1:0]           frac_sel,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW:0]   p,
  output logic signed [DW:0]   q
);
  localparam int OW = DW + 1;

  twc_acc_t ax, bx, sum_p, sum_q, full_p, full_q;
  twc_acc_t op  [2];
  twc_acc_t kc1 [2];
  twc_acc_t ks1 [2];
  twc_acc_t kc2 [2];
  logic     sel_sum;

  assign ax = {{(TWC_ACC_W-DW){a[DW-1]}}, a};
  assign bx = {{(TWC_ACC_W-DW){b[DW-1]}}, b};

  // the 45-degree case feeds a+b and b-a through the same two lanes
  assign sel_sum = (frac_sel == 2'd2);
  assign op[0]   = sel_sum ? (ax + bx) : ax;
  assign op[1]   = sel_sum ? (bx - ax) : bx;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    twc_shift_lane u_lane (
      .x   (op[g]),
      .kc1 (kc1[g]),
      .ks1 (ks1[g]),
      .kc2 (kc2[g])
    );
  end

  always_comb begin
    unique case (frac_sel)
      2'd1: begin  // R6
        sum_p = kc1[0] + ks1[1];
        sum_q = kc1[1] - ks1[0];
      end
      2'd2: begin  // R7
        sum_p = kc2[0];
        sum_q = kc2[1];
      end
      default: begin  // R8 (fraction 0 is bypassed upstream)
        sum_p = ks1[0] + kc1[1];
        sum_q = ks1[1] - kc1[0];
      end
    endcase
  end

  assign full_p = twc_floor(sum_p);
  assign full_q = twc_floor(sum_q);
  assign p      = full_p[OW-1:0];
  assign q      = full_q[OW-1:0];

  // R9: the truncated product always fits the output width
  always_comb begin
    p_no_overflow_r9: assert (full_p == {{(TWC_ACC_W-OW){p[OW-1]}}, p}
                           && full_q == {{(TWC_ACC_W-OW){q[OW-1]}}, q})
      else $error("truncated product exceeds output width");
  end
endmodule

// File: rtl/twc_quad_rotate.sv
module twc_quad_rotate #(
  parameter int OW = 14
)(
  input  logic [1:0]           quad,
  input  logic signed [OW-1:0] p,
  input  logic signed [OW-1:0] q,
  output logic signed [OW-1:0] re,
  output logic signed [OW-1:0] im
);
  // R9: multiply by (-j)^quad
  always_comb begin
    unique case (quad)
      2'd0: begin re = p;  im = q;  end
      2'd1: begin re = q;  im = -p; end
      2'd2: begin re = -p; im = -q; end
      default: begin re = -q; im = p; end
    endcase
  end
endmodule

// File: rtl/twiddle_const_mult.sv
module twiddle_const_mult
  import twc_pkg::*;
#(
  parameter int DW = 13
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [3:0]           in_tw_idx,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic signed [DW:0]   out_re,
  output logic signed [DW:0]   out_im
);
  localparam int OW = DW + 1;

  logic [1:0]           frac_sel, quad;
  logic                 bypass;
  logic signed [OW-1:0] core_p, core_q, pre_p, pre_q, rot_re, rot_im;

  twc_index_decode u_dec (
    .idx      (in_tw_idx),
    .frac_sel (frac_sel),
    .quad     (quad),
    .bypass   (bypass)
  );

  twc_const_core #(.DW(DW)) u_core (
    .frac_sel (frac_sel),
    .a        (in_re),
    .b        (in_im),
    .p        (core_p),
    .q        (core_q)
  );

  // R4: multiples of four skip the constants entirely
  assign pre_p = bypass ? {in_re[DW-1], in_re} : core_p;
  assign pre_q = bypass ? {in_im[DW-1], in_im} : core_q;

  twc_quad_rotate #(.OW(OW)) u_rot (
    .quad (quad),
    .p    (pre_p),
    .q    (pre_q),
    .re   (rot_re),
    .im   (rot_im)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_re <= rot_re;
        out_im <= rot_im;
      end
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)))
    else $error("out_valid does not follow in_valid");

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_re) && $stable(out_im)))
    else $error("output moved while idle");

  p_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(in_tw_idx) == 4'd0)
      |-> (out_re == $past(in_re) && out_im == $past(in_im)))
    else $error("index 0 did not pass the sample through");

  p_half_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(in_tw_idx) == 4'd8)
      |-> (out_re == -$past(in_re) && out_im == -$past(in_im)))
    else $error("index 8 did not negate the sample");
endmodule

// File: tb/twiddle_const_mult_tb_top.sv
module twiddle_const_mult_tb_top;
  localparam int DW = 13;
  localparam int OW = DW + 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [3:0]           in_tw_idx = '0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic                 out_valid;
  logic signed [OW-1:0] out_re, out_im;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint exp_re_q[$];
  longint exp_im_q[$];
  int     exp_m_q[$];
  longint last_re = 0, last_im = 0;
  bit     hold_armed = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;  // 250 MHz

  twiddle_const_mult #(.DW(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_tw_idx (in_tw_idx),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
  );

  // reference: integer multiply by the R5 numerators, floor by arithmetic shift
  task automatic ref_rotate(input longint a, input longint b, input int m,
                            output longint er, output longint ei);
    longint p, q;
    case (m % 4)
      0: begin p = a; q = b; end
      1: begin p = (a*7568 + b*3137) >>> 13; q = (b*7568 - a*3137) >>> 13; end
      2: begin p = ((a+b)*5794) >>> 13;      q = ((b-a)*5794) >>> 13; end
      default: begin p = (a*3137 + b*7568) >>> 13; q = (b*3137 - a*7568) >>> 13; end
    endcase
    case (m / 4)
      0: begin er = p;  ei = q;  end
      1: begin er = q;  ei = -p; end
      2: begin er = -p; ei = -q; end
      default: begin er = -q; ei = p; end
    endcase
  endtask

  function automatic string tag_of(input int m);
    string t;
    case (m % 4)
      0: t = "R4";
      1: t = "R6";
      2: t = "R7";
      default: t = "R8";
    endcase
    if (m / 4 != 0) t = {t, "+R9"};
    return t;
  endfunction

  function automatic int unsigned next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic drive(input logic signed [DW-1:0] a, input logic signed [DW-1:0] b,
                       input int m);
    longint er, ei;
    @(negedge clk);
    in_valid  = 1'b1;
    in_tw_idx = 4'(m);
    in_re     = a;
    in_im     = b;
    ref_rotate(longint'(a), longint'(b), m, er, ei);
    exp_re_q.push_back(er);
    exp_im_q.push_back(ei);
    exp_m_q.push_back(m);
  endtask

  // R3: idle cycles carry junk on data and index pins
  task automatic idle();
    int unsigned r;
    @(negedge clk);
    r = next_rand();
    in_valid  = 1'b0;
    in_tw_idx = r[3:0];
    in_re     = r[16:4];
    in_im     = r[29:17];
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && hold_armed && !done) begin
      if (out_valid) begin
        checks++;
        if (exp_re_q.size() == 0) begin
          errors++;
          $display("FAIL R2: result with nothing pending, got %0d %0d expected none",
                   out_re, out_im);
        end else begin
          longint er, ei;
          int m;
          er = exp_re_q.pop_front();
          ei = exp_im_q.pop_front();
          m  = exp_m_q.pop_front();
          if (longint'(out_re) != er || longint'(out_im) != ei) begin
            errors++;
            $display("FAIL %s (m=%0d): got (%0d,%0d) expected (%0d,%0d)",
                     tag_of(m), m, out_re, out_im, er, ei);
          end
        end
        last_re = longint'(out_re);
        last_im = longint'(out_im);
      end else begin
        checks++;
        if (longint'(out_re) != last_re || longint'(out_im) != last_im) begin
          errors++;
          $display("FAIL R3: idle output moved, got (%0d,%0d) expected (%0d,%0d)",
                   out_re, out_im, last_re, last_im);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic signed [DW-1:0] pa [8];
    logic signed [DW-1:0] pb [8];
    pa[0] = 13'sd1000;  pb[0] = -13'sd2000;
    pa[1] = -13'sd4096; pb[1] = -13'sd4096;
    pa[2] = 13'sd4095;  pb[2] = 13'sd4095;
    pa[3] = -13'sd4096; pb[3] = 13'sd4095;
    pa[4] = 13'sd0;     pb[4] = 13'sd0;
    pa[5] = 13'sd1;     pb[5] = -13'sd1;
    pa[6] = 13'sd4095;  pb[6] = -13'sd4096;
    pa[7] = -13'sd3;    pb[7] = 13'sd7;

    // R2: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_re !== '0 || out_im !== '0) begin
      errors++;
      $display("FAIL R2: reset state got v=%0b (%0d,%0d) expected v=0 (0,0)",
               out_valid, out_re, out_im);
    end
    rst_n = 1'b1;
    hold_armed = 1;

    // directed patterns across all sixteen exponents (R1), back to back (R2)
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 16; m++) drive(pa[p], pb[p], m);
      idle();
      idle();
    end

    // pseudo-random sweep with random gaps
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = next_rand();
      drive(r[12:0], r[25:13], int'(r[29:26]));
      if (r[31:30] == 2'b00) begin
        for (int g = 0; g < int'(r[2:0]) + 1; g++) idle();
      end
    end

    for (int i = 0; i < 6; i++) idle();

    // R2: every accepted sample produced exactly one result
    checks++;
    if (exp_re_q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending results got %0d expected 0", exp_re_q.size());
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule